// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a three-wire serial audio stream (bit clock, word clock, data) and turns it into one signed 24-bit sample per channel for a stereo pair. The three serial lines are treated as asynchronous inputs. They are resynchronised to a system clock that must run at least eight times faster than the bit clock. Bits are taken on each detected rising edge of the bit clock.

Two static mode pins choose the framing and the word length. One selects right-justified or I2S framing. The other selects 24-bit or 16-bit words. In right-justified framing the word sits against the end of each half-frame. Its first bit therefore moves with the frame length, which may be 48 or 64 bit clocks. In I2S framing the word starts one bit clock after the word clock changes level. After each stereo pair completes, both channel samples are published at once, together with a one-cycle strobe.

Top module: `dual_fmt_audio_rx`

## Requirements
- R1: While reset is low, and right after it is released, both sample outputs read zero and the strobe is low.
- R2: Data is sampled on the rising edges of the bit clock. Words arrive MSB first as two's complement values.
- R3: With `fmtI2s` = 0 (right-justified), a high word clock marks the left channel and a low one marks the right channel. The LSB is the bit taken on the last rising edge before the word clock changes. This holds for frames of 48 and 64 bit clocks.
- R4: With `fmtI2s` = 1 (I2S), a low word clock marks the left channel and a high one marks the right channel. The MSB is the bit taken on the second rising edge after the word clock changes. 24-bit words need 64-clock frames; 16-bit words fit 48- or 64-clock frames.
- R5: With `len16` = 0 the word is 24 bits long. With `len16` = 1 it is 16 bits long, and it appears on output bits 23:8 with bits 7:0 equal to zero.
- R6: Each completed right-channel word produces exactly one strobe, which lasts one cycle. `leftOut` then carries the most recent completed left word and `rightOut` carries that right word.
- R7: The strobe and the new outputs are visible after the third system clock rising edge following the bit clock edge that completes the right word.
- R8: Bit slots outside the word have no effect on either output.
- R9: No word is taken from the partial half-frame that precedes the first word clock change after reset.
- R10: Between strobes both sample outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock, asynchronous |
| wordClk | input | 1 | Left/right word clock, asynchronous |
| serData | input | 1 | Serial audio data, asynchronous |
| fmtI2s | input | 1 | Framing select: 0 right-justified, 1 I2S (static) |
| len16 | input | 1 | Word length select: 0 24-bit, 1 16-bit (static) |
| leftOut | output | 24 | Left sample, updated with the strobe |
| rightOut | output | 24 | Right sample, updated with the strobe |
| sampleValid | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
A bit clock rising edge passes through two synchroniser flops before it is seen. The registered outputs then add one more edge, so a stereo pair is due exactly three system clock edges after the bit clock edge that finishes the right word. For right-justified framing, that edge is the first one of the next left half-frame. For I2S framing, it is the edge carrying the right LSB. The bench stamps the cycle of every bit clock rise it drives. It compares each strobe with that stamp and with a queue of expected pairs, and samples on the falling system clock edge. It also checks that the strobe count per run equals the number of frames sent, which exposes strobes from lead-in data, and that the outputs never move between strobes.

// File: rtl/afrx_pkg.sv
package afrx_pkg;

  // Per-cycle commands from the control path to the datapath
  typedef struct packed {
    logic shiftEn;   // a bit clock rising edge was seen this cycle
    logic useOld;    // take the word from the register before this shift
    logic capLeft;   // a left word completes this cycle
    logic capRight;  // a right word completes this cycle
  } afrxStrobe_t;

endpackage

// File: rtl/afrx_sync.sv
module afrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/afrx_ctrl.sv
module afrx_ctrl
  import afrx_pkg::*;
#(
  parameter int LONG_W   = 24,
  parameter int SHORT_W  = 16,
  parameter int MAX_HALF = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bclkS,
  input  logic        wcS,
  input  logic        fmtI2s,
  input  logic        len16,
  output afrxStrobe_t strb
);

  localparam int CW = $clog2(MAX_HALF + 1) + 1;
  localparam logic [CW-1:0] CNT_SAT = '1;

  logic          bclkLast;
  logic          wcPrev;
  logic          started;
  logic          armed;
  logic [CW-1:0] cnt;

  logic          bitEdge;
  logic          wcFlip;
  logic [CW-1:0] cntNext;
  logic [CW-1:0] wordLen;
  logic          rjDone;
  logic          i2sDone;
  logic          doneLeft;

  always_comb begin
    bitEdge = bclkS & ~bclkLast;
    wcFlip  = started & (wcS != wcPrev);
    if (wcFlip) begin
      cntNext = '0;
    end else if (cnt == CNT_SAT) begin
      cntNext = cnt;
    end else begin
      cntNext = cnt + CW'(1);
    end
    wordLen  = len16 ? CW'(SHORT_W) : CW'(LONG_W);
    // Right-justified: the half that just ended is complete on the flip
    rjDone   = bitEdge & wcFlip & armed & ~fmtI2s;
    // I2S: the last word bit sits wordLen slots after the flip slot
    i2sDone  = bitEdge & fmtI2s & (cntNext == wordLen);
    doneLeft = fmtI2s ? ~wcS : wcPrev;

    strb.shiftEn  = bitEdge;
    strb.useOld   = ~fmtI2s;
    strb.capLeft  = (rjDone | i2sDone) & doneLeft;
    strb.capRight = (rjDone | i2sDone) & ~doneLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkLast <= 1'b0;
      wcPrev   <= 1'b0;
      started  <= 1'b0;
      armed    <= 1'b0;
      cnt      <= CNT_SAT;
    end else begin
      bclkLast <= bclkS;
      if (bitEdge) begin
        wcPrev  <= wcS;
        started <= 1'b1;
        cnt     <= cntNext;
        if (wcFlip) begin
          armed <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/afrx_datapath.sv
module afrx_datapath
  import afrx_pkg::*;
#(
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dS,
  input  logic              len16,
  input  afrxStrobe_t       strb,
  output logic [LONG_W-1:0] leftOut,
  output logic [LONG_W-1:0] rightOut,
  output logic              valid
);

  localparam int PAD = LONG_W - SHORT_W;

  logic [LONG_W-1:0] shReg;
  logic [LONG_W-1:0] shNext;
  logic [LONG_W-1:0] src;
  logic [LONG_W-1:0] word;
  logic [LONG_W-1:0] leftHold;

  assign shNext = {shReg[LONG_W-2:0], dS};
  assign src    = strb.useOld ? shReg : shNext;

  generate
    if (PAD > 0) begin : g_pad
      assign word = len16 ? {src[SHORT_W-1:0], {PAD{1'b0}}} : src;
    end else begin : g_nopad
      assign word = src;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      leftHold <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= strb.capRight;
      if (strb.shiftEn) begin
        shReg <= shNext;
      end
      if (strb.capLeft) begin
        leftHold <= word;
      end
      if (strb.capRight) begin
        leftOut  <= leftHold;
        rightOut <= word;
      end
    end
  end

endmodule

// File: rtl/dual_fmt_audio_rx.sv
module dual_fmt_audio_rx
  import afrx_pkg::*;
#(
  parameter int LONG_W      = 24,
  parameter int SHORT_W     = 16,
  parameter int MAX_HALF    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              serData,
  input  logic              fmtI2s,
  input  logic              len16,
  output logic [LONG_W-1:0] leftOut,
  output logic [LONG_W-1:0] rightOut,
  output logic              sampleValid
);

  logic [2:0]  syncOut;
  afrxStrobe_t strb;

  afrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bitClk, wordClk, serData}),
    .dout (syncOut)
  );

  afrx_ctrl #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .MAX_HALF(MAX_HALF)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .bclkS  (syncOut[2]),
    .wcS    (syncOut[1]),
    .fmtI2s (fmtI2s),
    .len16  (len16),
    .strb   (strb)
  );

  afrx_datapath #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dS       (syncOut[0]),
    .len16    (len16),
    .strb     (strb),
    .leftOut  (leftOut),
    .rightOut (rightOut),
    .valid    (sampleValid)
  );

endmodule

// File: rtl/afrx_checker.sv
module afrx_checker #(
  parameter int LONG_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              len16,
  input logic [LONG_W-1:0] leftOut,
  input logic [LONG_W-1:0] rightOut,
  input logic              sampleValid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (leftOut == '0 && rightOut == '0 && !sampleValid));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)));

  // R5
  short_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && len16) |-> (leftOut[7:0] == 8'h00 && rightOut[7:0] == 8'h00));

endmodule

bind dual_fmt_audio_rx afrx_checker #(.LONG_W(LONG_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .len16       (len16),
  .leftOut     (leftOut),
  .rightOut    (rightOut),
  .sampleValid (sampleValid)
);

// File: tb/dual_fmt_audio_rx_test.sv
module dual_fmt_audio_rx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordClk = 1'b0;
  logic        serData = 1'b0;
  logic        fmtI2s = 1'b0;
  logic        len16 = 1'b0;
  logic [23:0] leftOut;
  logic [23:0] rightOut;
  logic        sampleValid;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int riseStamp = 0;
  int strobeCnt = 0;
  bit holdBad = 1'b0;
  logic [23:0] lastL = '0;
  logic [23:0] lastR = '0;
  string valTag = "R2";
  logic [23:0] expL[$];
  logic [23:0] expR[$];

  dual_fmt_audio_rx uut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .serData(serData), .fmtI2s(fmtI2s), .len16(len16),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic logic [23:0] expect_word(input logic [23:0] v, input logic short);
    return short ? {v[15:0], 8'h00} : v;
  endfunction

  // Monitor: sampled on falling edges, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        strobeCnt++;
        if (expL.size() == 0) begin
          chk(1'b0, "R9 R6 unexpected strobe", rightOut, 24'h0);
        end else begin
          logic [23:0] eL;
          logic [23:0] eR;
          eL = expL.pop_front();
          eR = expR.pop_front();
          chk(leftOut === eL, {valTag, " R6 R8 left"}, leftOut, eL);
          chk(rightOut === eR, {valTag, " R6 R8 right"}, rightOut, eR);
          chk((cyc - riseStamp) == 3, "R7 latency", 24'(cyc - riseStamp), 24'd3);
        end
        lastL = leftOut;
        lastR = rightOut;
      end else if (leftOut !== lastL || rightOut !== lastR) begin
        holdBad = 1'b1;
      end
    end
  end

  // One bit slot: low half then high half of the bit clock (R2)
  task automatic bit_out(input logic w, input logic d);
    bitClk  = 1'b0;
    wordClk = w;
    serData = d;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    riseStamp = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic w, input int half, input logic [23:0] v,
                           input int n, input logic i2s);
    for (int k = 0; k < half; k++) begin
      logic d;
      d = 1'($urandom);
      if (!i2s && k >= half - n) d = v[n - 1 - (k - (half - n))];
      if (i2s && k >= 1 && k <= n) d = v[n - k];
      bit_out(w, d);
    end
  endtask

  task automatic run_group(input logic i2s, input logic short, input int frameBits, input int nFrames);
    int n;
    int half;
    logic leftLvl;
    n = short ? 16 : 24;
    half = frameBits / 2;
    leftLvl = i2s ? 1'b0 : 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    fmtI2s = i2s;
    len16 = short;
    bitClk = 1'b0;
    lastL = '0;
    lastR = '0;
    holdBad = 1'b0;
    strobeCnt = 0;
    repeat (3) @(negedge clk);
    chk(leftOut === 24'h0 && rightOut === 24'h0 && sampleValid === 1'b0,
        "R1 reset state", leftOut | rightOut, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(leftOut === 24'h0 && rightOut === 24'h0 && sampleValid === 1'b0,
        "R1 after release", leftOut | rightOut, 24'h0);
    valTag = i2s ? (short ? "R4 R5" : "R4") : (short ? "R3 R5" : "R3");
    // Lead-in partial half carrying a full word pattern (R9)
    send_half(~leftLvl, 8, 24'hFFFFFF, 8, i2s);
    for (int f = 0; f < nFrames; f++) begin
      logic [23:0] vl;
      logic [23:0] vr;
      vl = 24'($urandom);
      vr = 24'($urandom);
      if (f == 0) begin vl = 24'h7FFFFF; vr = 24'h800000; end
      if (f == 1) begin vl = 24'h000000; vr = 24'hFFFFFF; end
      if (f == 0 && short) begin vl = 24'h007FFF; vr = 24'h008000; end
      expL.push_back(expect_word(vl, short));
      expR.push_back(expect_word(vr, short));
      send_half(leftLvl, half, vl, n, i2s);
      send_half(~leftLvl, half, vr, n, i2s);
    end
    send_half(leftLvl, 4, 24'h0, 4, i2s);
    repeat (10) @(negedge clk);
    chk(strobeCnt == nFrames, "R6 R9 strobe count", 24'(strobeCnt), 24'(nFrames));
    chk(expL.size() == 0, "R6 missing strobes", 24'(expL.size()), 24'h0);
    chk(!holdBad, "R10 outputs held between strobes", 24'(holdBad), 24'h0);
    expL.delete();
    expR.delete();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    run_group(1'b0, 1'b0, 64, 6);
    run_group(1'b0, 1'b0, 48, 6);
    run_group(1'b0, 1'b1, 64, 6);
    run_group(1'b0, 1'b1, 48, 6);
    run_group(1'b1, 1'b0, 64, 6);
    run_group(1'b1, 1'b1, 64, 6);
    run_group(1'b1, 1'b1, 48, 6);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

endmodule